// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt request lines into two processor-facing request outputs and a hardware-computed handler address. Every input line passes through a two-flop synchronizer, is qualified by a per-source polarity bit and a per-source level/edge mode bit, and then sets a latched status bit. Software works with the status through a small register bank. Writing ones to the status word clears bits. A separate write ORs ones into the status, so software can raise a test interrupt. An enable word masks the status. A critical word sends each enabled pending source either to the critical output or to the non-critical output.

A vector register returns the handler address of the winning pending source. Only pending bits that are also enabled take part. The address is the base held in the vector configuration register, with its two low bits forced to zero, plus 512 bytes per priority slot. Bit 0 of the configuration picks the priority direction: either source 0 wins or source 31 wins.

The register bank uses word addresses and separate read and write strobes. Writes take effect on the clock edge where the strobe is high. Read data appears on the clock edge after the read strobe and is held until the next read.

Top module: `irq_vector_ctl`

## Requirements
- R1: Word addresses: 0 status (read, write-one-to-clear), 1 status set (write), 2 enable, 3 critical, 4 polarity, 5 mode, 6 masked status (read only), 7 vector (read only), 8 vector configuration. A write lands on the edge where `bus_wr` is high. Read data is registered on the edge where `bus_rd` is high and is held otherwise. After reset, polarity reads all ones, every other word reads zero, and `bus_rdata` is zero.
- R2: Source n uses bit 31-n of every register word and of `irq_in`, so source 0 is the MSB.
- R3: Writing a 1 to a bit of word 0 clears that status bit. A level-mode source whose input is still active sets the bit again, so it reads back as 1.
- R4: A write to word 1 ORs the written ones into status. Status bits written as 0 keep their value.
- R5: Polarity bit 1 makes the input active high and bit 0 makes it active low. With mode bit 0 (level), the status bit is set in every cycle the synchronized input is active.
- R6: With mode bit 1 (edge), the status bit is set once on each inactive-to-active transition. After a clear, it stays clear while the input is held active.
- R7: Word 6 reads status AND enable. `irq_crit` is high when an enabled pending bit has its critical bit at 1. `irq_norm` is high when an enabled pending bit has its critical bit at 0.
- R8: With configuration bit 0 at 1, the lowest-numbered enabled pending source n wins, and the vector reads base + n*512.
- R9: With configuration bit 0 at 0, the highest-numbered enabled pending source n wins, and the vector reads base + (31-n)*512. With nothing enabled and pending, the vector reads the base. The base is the configuration word with bits 1:0 cleared.
- R10: A change on `irq_in` reaches the status within four clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Raw interrupt lines, source n on bit 31-n |
| irq_crit | output | 1 | Critical request |
| irq_norm | output | 1 | Non-critical request |

## Verification
The bench goes after the priority ends: only source 0 pending, only source 31 pending, and nothing pending, each under both priority directions. A reversed scan or a wrong slot formula would return the address of the wrong handler, and a missing base fallback would return garbage when the controller is idle. It clears a level source while the source is still active, and it holds an edge source active across a clear. A design that mixed up the two modes would either lose the level request or retrigger the edge request. It also drives active-low sources, where inverted polarity handling would latch interrupts from idle lines. Random status, enable, critical and configuration words then compare the masked status, both request outputs and the vector against a bench model.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_STAT = 4'd0,
    RA_SET  = 4'd1,
    RA_ENAB = 4'd2,
    RA_CRIT = 4'd3,
    RA_POL  = 4'd4,
    RA_MODE = 4'd5,
    RA_MASK = 4'd6,
    RA_VEC  = 4'd7,
    RA_VCFG = 4'd8
  } reg_sel_e;

  // vector base: configuration word with its two low bits forced to zero
  function automatic logic [31:0] vec_base(input logic [31:0] cfg);
    return {cfg[31:2], 2'b00};
  endfunction
endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw_in,
  output logic [NSRC-1:0] sync_out
);
  logic [NSRC-1:0] stage1;

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[g]   <= 1'b0;
        sync_out[g] <= 1'b0;
      end else begin
        stage1[g]   <= raw_in[g];
        sync_out[g] <= stage1[g];
      end
    end
  end
endmodule

// File: rtl/irqv_detect.sv
module irqv_detect #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] line_sync,
  input  logic [NSRC-1:0] pol_hi,
  input  logic [NSRC-1:0] edge_mode,
  output logic [NSRC-1:0] hit
);
  logic [NSRC-1:0] active;
  logic [NSRC-1:0] active_q;

  // polarity 1 keeps the line, polarity 0 inverts it
  assign active = ~(line_sync ^ pol_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= active;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_comb begin
      if (edge_mode[g]) hit[g] = active[g] & ~active_q[g];
      else              hit[g] = active[g];
    end
  end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned STRIDE_LG = 9
) (
  input  logic [NSRC-1:0] pend,
  input  logic [31:0]     cfg,
  output logic [31:0]     vec,
  output logic            found
);
  localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  // lowest source number with a pending bit (source n lives on bit NSRC-1-n)
  function automatic logic [IW-1:0] first_low(input logic [NSRC-1:0] p);
    logic [IW-1:0] r;
    r = '0;
    for (int n = NSRC - 1; n >= 0; n--)
      if (p[NSRC-1-n]) r = IW'(n);
    return r;
  endfunction

  // highest source number with a pending bit
  function automatic logic [IW-1:0] first_high(input logic [NSRC-1:0] p);
    logic [IW-1:0] r;
    r = '0;
    for (int n = 0; n < NSRC; n++)
      if (p[NSRC-1-n]) r = IW'(n);
    return r;
  endfunction

  function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                            input logic [IW-1:0] slot);
    return base + (32'(slot) << STRIDE_LG);
  endfunction

  logic [IW-1:0] win;
  logic [IW-1:0] slot;

  always_comb begin
    found = |pend;
    if (cfg[0]) begin
      win  = first_low(pend);
      slot = win;
    end else begin
      win  = first_high(pend);
      slot = IW'(NSRC - 1) - win;
    end
    vec = found ? slot_addr(irqv_pkg::vec_base(cfg), slot) : irqv_pkg::vec_base(cfg);
  end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned STRIDE_LG = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [irqv_pkg::REG_AW-1:0] bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NSRC-1:0]            irq_in,
  output logic                       irq_crit,
  output logic                       irq_norm
);
  import irqv_pkg::*;

  logic [NSRC-1:0] stat_q, enab_q, crit_q, pol_q, mode_q;
  logic [31:0]     vcfg_q;
  logic [NSRC-1:0] line_sync, hit_w, masked_w, clr_w, set_w;
  logic [31:0]     vec_w;
  logic            vec_found;

  irqv_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(irq_in), .sync_out(line_sync)
  );

  irqv_detect #(.NSRC(NSRC)) u_det (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync),
    .pol_hi(pol_q), .edge_mode(mode_q), .hit(hit_w)
  );

  assign masked_w = stat_q & enab_q;

  irqv_prio #(.NSRC(NSRC), .STRIDE_LG(STRIDE_LG)) u_prio (
    .pend(masked_w), .cfg(vcfg_q), .vec(vec_w), .found(vec_found)
  );

  assign clr_w = (bus_wr && bus_addr == RA_STAT) ? bus_wdata[NSRC-1:0] : '0;
  assign set_w = (bus_wr && bus_addr == RA_SET)  ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      enab_q <= '0;
      crit_q <= '0;
      pol_q  <= '1;
      mode_q <= '0;
      vcfg_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_w) | hit_w | set_w;
      if (bus_wr) begin
        case (bus_addr)
          RA_ENAB: enab_q <= bus_wdata[NSRC-1:0];
          RA_CRIT: crit_q <= bus_wdata[NSRC-1:0];
          RA_POL:  pol_q  <= bus_wdata[NSRC-1:0];
          RA_MODE: mode_q <= bus_wdata[NSRC-1:0];
          RA_VCFG: vcfg_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      RA_STAT: rd_mux = 32'(stat_q);
      RA_ENAB: rd_mux = 32'(enab_q);
      RA_CRIT: rd_mux = 32'(crit_q);
      RA_POL:  rd_mux = 32'(pol_q);
      RA_MODE: rd_mux = 32'(mode_q);
      RA_MASK: rd_mux = 32'(masked_w);
      RA_VEC:  rd_mux = vec_w;
      RA_VCFG: rd_mux = vcfg_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq_crit = |(masked_w & crit_q);
  assign irq_norm = |(masked_w & ~crit_q);
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned STRIDE_LG = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [irqv_pkg::REG_AW-1:0] bus_addr,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [31:0]                 bus_wdata,
  input logic [31:0]                 bus_rdata,
  input logic                        irq_crit,
  input logic                        irq_norm,
  input logic [NSRC-1:0]             stat_q,
  input logic [NSRC-1:0]             enab_q,
  input logic [NSRC-1:0]             mode_q,
  input logic [NSRC-1:0]             hit_w,
  input logic [31:0]                 vcfg_q,
  input logic [31:0]                 vec_w
);
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == irqv_pkg::RA_STAT && bus_wdata[NSRC-1:0] == '1 && hit_w == '0)
      |=> stat_q == '0);

  p_set_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == irqv_pkg::RA_SET)
      |=> ((stat_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w & $past(hit_w) & mode_q & $past(mode_q)) == '0);

  p_quiet_when_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enab_q == '0 |-> (!irq_crit && !irq_norm));

  p_idle_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & enab_q) == '0 |-> vec_w == {vcfg_q[31:2], 2'b00});

  p_stride_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_w[STRIDE_LG-1:0] == {vcfg_q[STRIDE_LG-1:2], 2'b00});
endmodule

bind irq_vector_ctl irqv_chk #(.NSRC(NSRC), .STRIDE_LG(STRIDE_LG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_crit(irq_crit), .irq_norm(irq_norm), .stat_q(stat_q),
  .enab_q(enab_q), .mode_q(mode_q), .hit_w(hit_w), .vcfg_q(vcfg_q),
  .vec_w(vec_w)
);

// File: tb/test_irq_vector_ctl.sv
module test_irq_vector_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        irq_crit, irq_norm;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  irq_vector_ctl i_irq_vector_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_crit(irq_crit), .irq_norm(irq_norm)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run exceeded cycle limit (actual %0d expected <100000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] bit_of(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  function automatic logic [31:0] model_vec(input logic [31:0] pend, input logic [31:0] cfg);
    logic [31:0] base;
    base = cfg & ~32'h3;
    if (cfg[0]) begin
      for (int n = 0; n < 32; n++)
        if (pend & bit_of(n)) return base + n * 512;
    end else begin
      for (int n = 31; n >= 0; n--)
        if (pend & bit_of(n)) return base + (31 - n) * 512;
    end
    return base;
  endfunction

  logic [31:0] d;

  initial begin
    void'($urandom(32'h5EED_0042));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset values
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd(4'd0, d); check("R1 status reset", d, 32'h0);
    rd(4'd2, d); check("R1 enable reset", d, 32'h0);
    rd(4'd4, d); check("R1 polarity reset", d, 32'hFFFF_FFFF);
    rd(4'd5, d); check("R1 mode reset", d, 32'h0);
    rd(4'd7, d); check("R1 vector reset", d, 32'h0);

    // R1 read-back of writable words
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v;
      v = $urandom();
      wr(4'd3, v); rd(4'd3, d); check("R1 critical readback", d, v);
      wr(4'd8, v); rd(4'd8, d); check("R1 vcfg readback", d, v);
    end

    // R4 / R7 / R8 / R9 random: inputs idle, polarity high, level mode
    wr(4'd4, 32'hFFFF_FFFF); wr(4'd5, 32'h0);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] st, en, cr, cfg;
      st  = $urandom() & $urandom() & $urandom();
      en  = $urandom() | $urandom();
      cr  = $urandom();
      cfg = $urandom();
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, st);
      wr(4'd2, en); wr(4'd3, cr); wr(4'd8, cfg);
      rd(4'd0, d); check("R4 status set", d, st);
      rd(4'd6, d); check("R7 masked status", d, st & en);
      check("R7 irq_crit", {31'b0, irq_crit}, {31'b0, |(st & en & cr)});
      check("R7 irq_norm", {31'b0, irq_norm}, {31'b0, |(st & en & ~cr)});
      rd(4'd7, d);
      check(cfg[0] ? "R8 vector low first" : "R9 vector high first", d, model_vec(st & en, cfg));
    end

    // R4 set keeps zeros, R3 partial clear
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'h00F0_0F00);
    wr(4'd1, 32'h0000_0001);
    rd(4'd0, d); check("R4 OR accumulate", d, 32'h00F0_0F01);
    wr(4'd0, 32'h0030_0100);
    rd(4'd0, d); check("R3 partial clear", d, 32'h00C0_0E01);

    // R8 / R9 directed ends
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, bit_of(0) | bit_of(31));
    wr(4'd8, 32'h1000_0003); rd(4'd7, d); check("R8 source 0 wins", d, 32'h1000_0000);
    wr(4'd8, 32'h1000_0002); rd(4'd7, d); check("R9 source 31 wins", d, 32'h1000_0000);
    wr(4'd0, bit_of(0));
    wr(4'd8, 32'h1000_0001); rd(4'd7, d); check("R8 only source 31", d, 32'h1000_0000 + 31 * 512);
    wr(4'd0, bit_of(31)); wr(4'd1, bit_of(0));
    wr(4'd8, 32'h1000_0000); rd(4'd7, d); check("R9 only source 0", d, 32'h1000_0000 + 31 * 512);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd8, 32'h2000_0007); rd(4'd7, d); check("R9 nothing pending base", d, 32'h2000_0004);

    // R2 / R5 / R10 level, active high, source 5
    irq_in = bit_of(5);
    idle(4);
    rd(4'd0, d); check("R10 R2 level source 5 latched", d, bit_of(5));
    wr(4'd0, bit_of(5));
    rd(4'd0, d); check("R3 level still active re-sets", d, bit_of(5));
    irq_in = '0;
    idle(4);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d); check("R5 level released clears", d, 32'h0);

    // R5 active low on source 9
    wr(4'd4, ~bit_of(9));
    idle(4);
    rd(4'd0, d); check("R5 active-low idle line sets", d, bit_of(9));
    irq_in = bit_of(9);
    idle(4);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d); check("R5 active-low high line quiet", d, 32'h0);
    wr(4'd4, 32'hFFFF_FFFF);
    irq_in = '0;
    idle(4);
    wr(4'd0, 32'hFFFF_FFFF);

    // R6 edge mode on source 20
    wr(4'd5, bit_of(20));
    irq_in = bit_of(20);
    idle(4);
    rd(4'd0, d); check("R6 edge sets", d, bit_of(20));
    wr(4'd0, bit_of(20));
    idle(4);
    rd(4'd0, d); check("R6 held edge stays clear", d, 32'h0);
    irq_in = '0;
    idle(4);
    irq_in = bit_of(20);
    idle(4);
    rd(4'd0, d); check("R6 second edge sets", d, bit_of(20));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule